// File: doc/BRIEF.md
# Self-Checking RC6 Encryption Datapath

This block encrypts one 128-bit block with the RC6 cipher (32-bit words, 20 rounds) on an iterative datapath. The datapath has two quadratic units, one per multiplier, each computing `rotl(x*(2x+1), 5)`, and two mix units, each computing `rotl(x ^ p, q[4:0]) + key`. A fixed 42-cycle schedule drives them. Cycle 0 adds the whitening keys to B and D. The next 40 cycles take the rounds in pairs: an odd cycle runs the quadratic units, and the even cycle after it runs the mix units and rotates the state words. Cycle 41 adds the final whitening keys to A and C.

Each unit is therefore idle every other cycle. In its idle cycle the unit recomputes its last result from held copies of that result's inputs and compares the new value with a stored copy of the first one. A difference sets a sticky error flag. Errors are detected without a second copy of the arithmetic. The mix units of the last round run their check in the post-whitening cycle. Each unit has one test input that forces its output to all ones and one that forces it to all zeros. A fault on either input in the cycle of a first computation corrupts the ciphertext, and the check flags it. A fault in the cycle of a recomputation flags an error and leaves the ciphertext correct.

The caller supplies all 44 round keys and holds them stable for the whole run. Key expansion and decryption are not part of this block.

Top module: `rc6_ced_core`

## Requirements
- R1: After reset, `done` and `err` are 0 and `ciphertext` is all zeros.
- R2: The plaintext packs words as A=[31:0], B=[63:32], C=[95:64], D=[127:96]. The ciphertext uses the same packing. Round key k sits at `round_keys[32k+31:32k]`.
- R3: The ciphertext equals RC6 encryption of the plaintext: pre-whitening with keys 0 and 1, twenty rounds using keys 2i and 2i+1, and post-whitening with keys 42 and 43. All arithmetic is modulo 2^32.
- R4: `done` is a single-cycle pulse. It goes high on the 42nd rising edge after the edge that samples `start`.
- R5: `ciphertext` holds its value from the `done` pulse until the next `start`.
- R6: A run with no fault input asserted ends with `err` at 0.
- R7: A quadratic-unit fault during its first computation (an odd cycle) sets `err` and changes the ciphertext.
- R8: A quadratic-unit fault during its idle recomputation (an even cycle from 2 to 40) sets `err` and leaves the ciphertext correct.
- R9: A mix-unit fault during its first computation (an even cycle) sets `err` and changes the ciphertext. A mix-unit fault during its recomputation (an odd cycle from 3 to 39) sets `err` and leaves the ciphertext correct.
- R10: Once set, `err` stays high until the next `start`. A `start` clears it.
- R11: Each unit has two fault inputs. A bit of `fi_sa1` forces the unit's output to all ones, and a bit of `fi_sa0` forces it to all zeros. Both act only in the cycle in which they are high. Unit index 0 is the B quadratic unit, 1 the D quadratic unit, 2 the A mix unit and 3 the C mix unit.
- R12: The last round's mix results are rechecked in cycle 41. A mix-unit fault in that cycle sets `err` by the time `done` is high and leaves the ciphertext correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the plaintext and begins a run |
| plaintext | input | 128 | Block to encrypt |
| round_keys | input | 1408 | 44 round keys of 32 bits each, key k at bit 32k |
| fi_sa1 | input | 4 | Per-unit test input: force the output to all ones |
| fi_sa0 | input | 4 | Per-unit test input: force the output to all zeros |
| ciphertext | output | 128 | Encrypted block |
| done | output | 1 | One-cycle pulse at the end of a run |
| err | output | 1 | Sticky flag: a recomputed result differed from its first result |

## Verification
Clean runs use three plaintexts: all zeros, all ones and a mixed word pattern. Together they expose errors in word order, rotation amount and key indexing against an independent reference. Single-cycle faults are placed on each unit in both its working cycle and its idle cycle. The outcome (ciphertext wrong with `err` set, against ciphertext right with `err` set) separates a corrupted computation from a corrupted check. Both forcing polarities are used, and a mix-unit fault is placed in the post-whitening cycle. A clean run after a faulty one shows that `start` clears the flag.

// File: rtl/rc6_ced_pkg.sv
package rc6_ced_pkg;
    localparam int WORD_W = 32;
    localparam int ROT_W  = $clog2(WORD_W);
    localparam int QROT   = 5;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t d;
        word_t c;
        word_t b;
        word_t a;
    } blk_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_MUL,
        PH_MIX,
        PH_POST
    } phase_t;

    function automatic word_t rotl(input word_t x, input logic [ROT_W-1:0] n);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << n;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction

    function automatic word_t quad_fn(input word_t x);
        word_t prod;
        prod = x * ((x << 1) + word_t'(1));
        return rotl(prod, ROT_W'(QROT));
    endfunction

    function automatic word_t mix_fn(input word_t x, input word_t p,
                                     input word_t q, input word_t k);
        return rotl(x ^ p, q[ROT_W-1:0]) + k;
    endfunction

    function automatic word_t force_out(input word_t v, input logic hi, input logic lo);
        return (v | {WORD_W{hi}}) & ~{WORD_W{lo}};
    endfunction
endpackage

// File: rtl/rc6_quad_unit.sv
module rc6_quad_unit
    import rc6_ced_pkg::*;
(
    input  word_t x,
    input  logic  fi_hi,
    input  logic  fi_lo,
    output word_t y
);
    always_comb y = force_out(quad_fn(x), fi_hi, fi_lo);
endmodule

// File: rtl/rc6_mix_unit.sv
module rc6_mix_unit
    import rc6_ced_pkg::*;
(
    input  word_t x,
    input  word_t p,
    input  word_t q,
    input  word_t k,
    input  logic  fi_hi,
    input  logic  fi_lo,
    output word_t y
);
    always_comb y = force_out(mix_fn(x, p, q, k), fi_hi, fi_lo);
endmodule

// File: rtl/rc6_sched.sv
module rc6_sched
    import rc6_ced_pkg::*;
#(
    parameter int NCYC = 42,
    localparam int CW  = $clog2(NCYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] cyc,
    output phase_t        phase,
    output logic          chk_quad,
    output logic          chk_mix
);
    localparam logic [CW-1:0] LAST = CW'(NCYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            cyc  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cyc  <= '0;
            end else if (busy) begin
                if (cyc == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cyc <= cyc + CW'(1);
                end
            end
        end
    end

    always_comb begin
        if (!busy)            phase = PH_IDLE;
        else if (cyc == '0)   phase = PH_PRE;
        else if (cyc == LAST) phase = PH_POST;
        else if (cyc[0])      phase = PH_MUL;
        else                  phase = PH_MIX;
    end

    // Quadratic units recheck in mix cycles; mix units recheck in later
    // multiply cycles and in the post-whitening cycle.
    assign chk_quad = (phase == PH_MIX);
    assign chk_mix  = (phase == PH_POST) || ((phase == PH_MUL) && (cyc != CW'(1)));
endmodule

// File: rtl/rc6_ced_core.sv
module rc6_ced_core
    import rc6_ced_pkg::*;
#(
    parameter int NROUND = 20,
    localparam int NCYC  = 2 * NROUND + 2,
    localparam int NKEY  = 2 * NROUND + 4,
    localparam int CW    = $clog2(NCYC + 1),
    localparam int BLK_W = 4 * WORD_W,
    localparam int NUNIT = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [BLK_W-1:0]       plaintext,
    input  logic [NKEY*WORD_W-1:0] round_keys,
    input  logic [NUNIT-1:0]       fi_sa1,
    input  logic [NUNIT-1:0]       fi_sa0,
    output logic [BLK_W-1:0]       ciphertext,
    output logic                   done,
    output logic                   err
);
    logic          busy;
    logic [CW-1:0] cyc;
    phase_t        phase;
    logic          chk_quad, chk_mix;

    rc6_sched #(.NCYC(NCYC)) u_sched (
        .clk(clk), .rst(rst), .start(start),
        .busy(busy), .done(done), .cyc(cyc), .phase(phase),
        .chk_quad(chk_quad), .chk_mix(chk_mix)
    );

    blk_t  st;
    word_t t_r, u_r;           // first quadratic results
    word_t qb_r, qd_r;         // quadratic inputs held for recheck
    word_t ma_r, mc_r;         // first mix results
    word_t ha_r, hc_r;         // mix inputs held for recheck
    word_t hk0_r, hk1_r;       // mix keys held for recheck

    // Keys of the current cycle: mix cycle k uses keys k and k+1.
    logic [$clog2(NKEY)-1:0] kidx;
    word_t key_lo, key_hi;
    always_comb begin
        case (phase)
            PH_PRE:  kidx = '0;
            PH_POST: kidx = ($clog2(NKEY))'(NCYC);
            default: kidx = ($clog2(NKEY))'(cyc);
        endcase
        key_lo = round_keys[kidx*WORD_W +: WORD_W];
        key_hi = round_keys[(kidx+1)*WORD_W +: WORD_W];
    end

    word_t q_in [2];
    word_t q_out[2];
    word_t m_x  [2];
    word_t m_p  [2];
    word_t m_q  [2];
    word_t m_k  [2];
    word_t m_out[2];
    logic  mul_live, mix_live;

    assign mul_live = (phase == PH_MUL);
    assign mix_live = (phase == PH_MIX);

    always_comb begin
        q_in[0] = mul_live ? st.b : qb_r;
        q_in[1] = mul_live ? st.d : qd_r;
        m_x[0]  = mix_live ? st.a : ha_r;
        m_x[1]  = mix_live ? st.c : hc_r;
        m_p[0]  = t_r;
        m_q[0]  = u_r;
        m_p[1]  = u_r;
        m_q[1]  = t_r;
        m_k[0]  = mix_live ? key_lo : hk0_r;
        m_k[1]  = mix_live ? key_hi : hk1_r;
    end

    for (genvar j = 0; j < 2; j++) begin : g_unit
        rc6_quad_unit u_quad (
            .x(q_in[j]), .fi_hi(fi_sa1[j]), .fi_lo(fi_sa0[j]), .y(q_out[j])
        );
        rc6_mix_unit u_mix (
            .x(m_x[j]), .p(m_p[j]), .q(m_q[j]), .k(m_k[j]),
            .fi_hi(fi_sa1[j+2]), .fi_lo(fi_sa0[j+2]), .y(m_out[j])
        );
    end

    logic mismatch;
    assign mismatch = (chk_quad && ((q_out[0] != t_r)  || (q_out[1] != u_r))) ||
                      (chk_mix  && ((m_out[0] != ma_r) || (m_out[1] != mc_r)));

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= '0;
            t_r   <= '0;
            u_r   <= '0;
            qb_r  <= '0;
            qd_r  <= '0;
            ma_r  <= '0;
            mc_r  <= '0;
            ha_r  <= '0;
            hc_r  <= '0;
            hk0_r <= '0;
            hk1_r <= '0;
            err   <= 1'b0;
        end else if (start) begin
            st  <= blk_t'(plaintext);
            err <= 1'b0;
        end else begin
            if (mismatch) err <= 1'b1;
            unique case (phase)
                PH_PRE: begin
                    st.b <= st.b + key_lo;
                    st.d <= st.d + key_hi;
                end
                PH_MUL: begin
                    t_r  <= q_out[0];
                    u_r  <= q_out[1];
                    qb_r <= st.b;
                    qd_r <= st.d;
                end
                PH_MIX: begin
                    ma_r  <= m_out[0];
                    mc_r  <= m_out[1];
                    ha_r  <= st.a;
                    hc_r  <= st.c;
                    hk0_r <= key_lo;
                    hk1_r <= key_hi;
                    st.a  <= st.b;
                    st.b  <= m_out[1];
                    st.c  <= st.d;
                    st.d  <= m_out[0];
                end
                PH_POST: begin
                    st.a <= st.a + key_lo;
                    st.c <= st.c + key_hi;
                end
                default: ;
            endcase
        end
    end

    assign ciphertext = st;
endmodule

// File: rtl/rc6_ced_chk.sv
module rc6_ced_chk #(
    parameter int BLK_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [BLK_W-1:0] ct
);
    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_done_ends_run: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(busy) && !busy));

    a_r5_ct_stable: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(ct));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (err && !start) |=> err);

    a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
        start |=> (!err && busy));

    a_r10_err_only_in_run: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(busy));
endmodule

bind rc6_ced_core rc6_ced_chk #(.BLK_W(BLK_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .done(done), .err(err), .ct(ciphertext)
);

// File: tb/rc6_ced_core_tb.sv
module rc6_ced_core_tb;
    localparam int NKEY = 44;

    logic               clk = 1'b0;
    logic               rst;
    logic               start;
    logic [127:0]       plaintext;
    logic [NKEY*32-1:0] round_keys;
    logic [3:0]         fi_sa1, fi_sa0;
    logic [127:0]       ciphertext;
    logic               done, err;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    rc6_ced_core u_dut (
        .clk(clk), .rst(rst), .start(start), .plaintext(plaintext),
        .round_keys(round_keys), .fi_sa1(fi_sa1), .fi_sa0(fi_sa0),
        .ciphertext(ciphertext), .done(done), .err(err)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input logic [4:0] n);
        return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
    endfunction

    function automatic logic [31:0] key(input int k);
        return round_keys[k*32 +: 32];
    endfunction

    function automatic logic [127:0] ref_enc(input logic [127:0] pt);
        logic [31:0] a, b, c, d, t, u, tmp;
        a = pt[31:0]; b = pt[63:32]; c = pt[95:64]; d = pt[127:96];
        b = b + key(0);
        d = d + key(1);
        for (int i = 1; i <= 20; i++) begin
            t = rl(b * (2 * b + 1), 5);
            u = rl(d * (2 * d + 1), 5);
            a = rl(a ^ t, u[4:0]) + key(2 * i);
            c = rl(c ^ u, t[4:0]) + key(2 * i + 1);
            tmp = a; a = b; b = c; c = d; d = tmp;
        end
        a = a + key(42);
        c = c + key(43);
        return {d, c, b, a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One run; fault applied during schedule cycle fcyc (-1 = none).
    task automatic run(input logic [127:0] pt, input int fcyc,
                       input logic [3:0] m1, input logic [3:0] m0,
                       output logic [127:0] ct, output logic e, output bit early);
        early = 0;
        @(negedge clk);
        plaintext = pt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 42; n++) begin
            if (done) early = 1;
            if (n == fcyc) begin fi_sa1 = m1; fi_sa0 = m0; end
            @(negedge clk);
            fi_sa1 = '0; fi_sa0 = '0;
        end
        ct = ciphertext;
        e  = err;
        check(done === 1'b1 && !early, "R4", "done on 42nd edge", {127'd0, done}, 128'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; plaintext = '0; fi_sa1 = '0; fi_sa0 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done === 1'b0 && err === 1'b0, "R1", "done/err after reset",
              {126'd0, done, err}, 128'd0);
        check(ciphertext === '0, "R1", "ciphertext after reset", ciphertext, 128'd0);
    endtask

    task automatic t_clean(input logic [127:0] pt);
        logic [127:0] ct, exp; logic e; bit early;
        exp = ref_enc(pt);
        run(pt, -1, 4'h0, 4'h0, ct, e, early);
        check(ct === exp, "R3", "ciphertext (R2 packing)", ct, exp);
        check(e === 1'b0, "R6", "err on clean run", {127'd0, e}, 128'd0);
        @(negedge clk);
        check(done === 1'b0, "R4", "done single cycle", {127'd0, done}, 128'd0);
        plaintext = ~pt;
        repeat (3) @(negedge clk);
        check(ciphertext === exp, "R5", "ciphertext held", ciphertext, exp);
    endtask

    // expect_ok: ciphertext should still be correct.
    task automatic t_fault(input string req, input logic [127:0] pt, input int fcyc,
                           input logic [3:0] m1, input logic [3:0] m0, input bit expect_ok);
        logic [127:0] ct, exp; logic e; bit early;
        exp = ref_enc(pt);
        run(pt, fcyc, m1, m0, ct, e, early);
        check(e === 1'b1, req, "err raised", {127'd0, e}, 128'd1);
        if (expect_ok)
            check(ct === exp, req, "ciphertext intact", ct, exp);
        else
            check(ct !== exp, req, "ciphertext corrupted", ct, ~exp);
    endtask

    task automatic t_sticky();
        logic [127:0] ct, exp; logic e; bit early;
        t_fault("R10", 128'h1, 7, 4'b0001, 4'b0000, 1'b0);
        repeat (5) @(negedge clk);
        check(err === 1'b1, "R10", "err held after run", {127'd0, err}, 128'd1);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err === 1'b0, "R10", "start clears err", {127'd0, err}, 128'd0);
        repeat (45) @(negedge clk);
        exp = ref_enc(128'h1);
        run(128'h1, -1, 4'h0, 4'h0, ct, e, early);
        check(e === 1'b0 && ct === exp, "R10", "clean run after fault", ct, exp);
    endtask

    initial begin
        for (int k = 0; k < NKEY; k++)
            round_keys[k*32 +: 32] = 32'h9E37_79B9 * (k + 3) ^ 32'h5A5A_0F0F;
        t_reset();
        t_clean('0);
        t_clean({128{1'b1}});
        t_clean(128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210);
        t_fault("R7",  128'hDEAD_BEEF, 5,  4'b0001, 4'b0000, 1'b0);
        t_fault("R7",  128'hCAFE,      1,  4'b0000, 4'b0010, 1'b0);
        t_fault("R8",  128'hDEAD_BEEF, 12, 4'b0010, 4'b0000, 1'b1);
        t_fault("R11", 128'h77,        20, 4'b0000, 4'b0001, 1'b1);
        t_fault("R9",  128'h55AA,      10, 4'b0100, 4'b0000, 1'b0);
        t_fault("R9",  128'h55AA,      15, 4'b1000, 4'b0000, 1'b1);
        t_fault("R11", 128'h1234,      23, 4'b0000, 4'b0100, 1'b1);
        t_fault("R12", 128'h9999,      41, 4'b1000, 4'b0000, 1'b1);
        t_sticky();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule